// File: doc/BRIEF.md
# Multi-Context Configuration Plane Manager

The block sits in front of a reconfigurable fabric that keeps four complete configuration planes, only one of which drives the logic at any moment. A requester presents a context ID per request. The block classifies each request into one of three outcomes. A **hit** means the wanted context is already on the active plane. A **switch** means another resident plane already holds it and only needs to be selected. A **load** means no plane holds it, so a whole plane must be rewritten. The plane that receives a load is an empty plane if one exists, and otherwise the least-recently-used resident plane.

Two one-hot select vectors come out of the block. One chooses the plane that executes. The other chooses the plane that is being programmed. A load is announced with a one-cycle command pulse that carries the target plane and context. The transfer then takes a fixed number of cycles, and the block refuses new requests until it is over. Running counts of loads and switches and a weighted overhead sum make the cost of a request stream visible. Each load adds a programmable load weight, and each switch adds a programmable switch weight.

Requests use valid/ready. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole duration of a load. While it is low, the requester must hold `req_valid` and `req_ctx` steady. Hits and switches are absorbed at one per cycle.

Top module: `ctx_plane_mgr`

## Requirements
- R1: `plane_sel` never has more than one bit set. It is all-zero from reset until the first load finishes, and it is one-hot after that.
- R2: A request whose context sits on the active plane is a hit. One cycle later `evt_valid` pulses with `evt_kind` = 0. `plane_sel`, both counters and `overhead_total` stay unchanged.
- R3: A request whose context is resident on an inactive plane is a switch. On the accepting edge `plane_sel` moves to that plane and `switch_count` rises by one. `overhead_total` rises by `switch_cost`, and `evt_kind` = 1 is reported one cycle later.
- R4: A request whose context is on no plane is a load. `load_count` rises by one and `overhead_total` rises by `load_cost`. One cycle later `evt_kind` = 2 is reported together with a one-cycle `load_start` that carries the target plane on `load_plane` and the context on `load_ctx`.
- R5: After reset all planes are empty. A load goes to the lowest-numbered empty plane while any plane is empty.
- R6: When all planes are occupied, a load replaces the plane that has gone unrequested the longest. Every accepted request, whatever its outcome, makes its plane the most recent.
- R7: After a load is accepted, `req_ready` is low for exactly LOAD_CYCLES cycles. During that time `prog_sel` is the one-hot of the target plane, and it is zero at all other times. When the load completes, the target plane becomes active without any switch being counted.
- R8: The weights are sampled on the accepting edge. Changing `load_cost` or `switch_cost` at any other time does not alter the amount already added.
- R9: During and right after reset, `req_ready` is 1. `plane_sel`, `prog_sel`, `load_start`, `evt_valid`, both counters and `overhead_total` are 0.
- R10: A request held with `req_valid` high while `req_ready` is low is accepted exactly once, on the first edge where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_ctx | input | CTX_W | Context ID requested |
| load_cost | input | WT_W | Overhead weight of one load |
| switch_cost | input | WT_W | Overhead weight of one switch |
| plane_sel | output | NUM_PLANES | One-hot execution plane select |
| prog_sel | output | NUM_PLANES | One-hot programming plane select during a load |
| load_start | output | 1 | One-cycle load command |
| load_plane | output | IDX_W | Plane targeted by the load command |
| load_ctx | output | CTX_W | Context written by the load command |
| evt_valid | output | 1 | Outcome report strobe |
| evt_kind | output | 2 | 0 hit, 1 switch, 2 load |
| load_count | output | CNT_W | Loads since reset |
| switch_count | output | CNT_W | Switches since reset |
| overhead_total | output | OVH_W | Weighted sum of loads and switches |

## Verification
The hardest state to reach from the ports is an eviction in which the least-recently-used plane is neither the lowest-numbered nor the most recently loaded plane. Reaching it takes a full set of planes whose recency order has been reshuffled by hits and switches. The stimulus first fills all four planes. It then runs long streams drawn from a pool of six context IDs with uneven reuse, so recency is shuffled again and again before each miss. Requests are kept back-to-back, with `req_valid` held through each load stall, and the weights change while loads are in flight.

// File: rtl/ctx_plane_pkg.sv
package ctx_plane_pkg;
  typedef enum logic [1:0] {
    OUT_HIT    = 2'd0,
    OUT_SWITCH = 2'd1,
    OUT_LOAD   = 2'd2
  } outcome_e;
endpackage

// File: rtl/ctx_tag_match.sv
module ctx_tag_match #(
  parameter int N     = 4,
  parameter int CTX_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][CTX_W-1:0] tags,
  input  logic [N-1:0]            filled,
  input  logic [CTX_W-1:0]        key,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = filled[g] && (tags[g] == key);
  end

  // lowest matching plane wins (at most one matches in practice)
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (match[p]) begin
        found = 1'b1;
        idx   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ctx_lru.sv
module ctx_lru #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     filled,
  output logic [IDX_W-1:0] victim
);
  // rank 0 = most recent, N-1 = oldest; ranks always form a permutation
  logic [N-1:0][IDX_W-1:0] ranks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) ranks[p] <= IDX_W'(p);
    end else if (touch) begin
      for (int p = 0; p < N; p++) begin
        if (IDX_W'(p) == touch_idx)
          ranks[p] <= '0;
        else if (ranks[p] < ranks[touch_idx])
          ranks[p] <= ranks[p] + 1'b1;
      end
    end
  end

  logic have_empty;
  always_comb begin
    have_empty = 1'b0;
    victim     = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (!filled[p]) begin
        have_empty = 1'b1;
        victim     = IDX_W'(p);
      end
    end
    if (!have_empty) begin
      for (int p = 0; p < N; p++)
        if (ranks[p] == IDX_W'(N - 1)) victim = IDX_W'(p);
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_perm
    logic [N-1:0] owners;
    for (genvar p = 0; p < N; p++) begin : g_own
      assign owners[p] = (ranks[p] == IDX_W'(k));
    end
    assert_rank_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owners) == 1);
  end
endmodule

// File: rtl/ctx_plane_dec.sv
module ctx_plane_dec #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  for (genvar p = 0; p < N; p++) begin : g_sel
    assign sel[p] = en && (idx == IDX_W'(p));
  end
endmodule

// File: rtl/ctx_plane_mgr.sv
module ctx_plane_mgr
  import ctx_plane_pkg::*;
#(
  parameter int NUM_PLANES  = 4,
  parameter int CTX_W       = 8,
  parameter int WT_W        = 16,
  parameter int CNT_W       = 16,
  parameter int OVH_W       = 40,
  parameter int LOAD_CYCLES = 6,
  localparam int IDX_W      = $clog2(NUM_PLANES),
  localparam int TMR_W      = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [CTX_W-1:0]      req_ctx,
  input  logic [WT_W-1:0]       load_cost,
  input  logic [WT_W-1:0]       switch_cost,
  output logic [NUM_PLANES-1:0] plane_sel,
  output logic [NUM_PLANES-1:0] prog_sel,
  output logic                  load_start,
  output logic [IDX_W-1:0]      load_plane,
  output logic [CTX_W-1:0]      load_ctx,
  output logic                  evt_valid,
  output logic [1:0]            evt_kind,
  output logic [CNT_W-1:0]      load_count,
  output logic [CNT_W-1:0]      switch_count,
  output logic [OVH_W-1:0]      overhead_total
);
  logic [NUM_PLANES-1:0][CTX_W-1:0] tags_q;
  logic [NUM_PLANES-1:0]            filled_q;
  logic [IDX_W-1:0]                 active_q, pend_q;
  logic                             active_vld_q;
  logic                             busy_q;
  logic [TMR_W-1:0]                 timer_q;

  logic             found;
  logic [IDX_W-1:0] found_idx, victim, touch_idx;
  logic             accept, is_hit, is_switch, is_load;

  ctx_tag_match #(.N(NUM_PLANES), .CTX_W(CTX_W), .IDX_W(IDX_W)) u_match (
    .tags(tags_q), .filled(filled_q), .key(req_ctx),
    .found(found), .idx(found_idx)
  );

  ctx_lru #(.N(NUM_PLANES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(accept), .touch_idx(touch_idx),
    .filled(filled_q), .victim(victim)
  );

  ctx_plane_dec #(.N(NUM_PLANES), .IDX_W(IDX_W)) u_exec_dec (
    .en(active_vld_q), .idx(active_q), .sel(plane_sel)
  );

  ctx_plane_dec #(.N(NUM_PLANES), .IDX_W(IDX_W)) u_prog_dec (
    .en(busy_q), .idx(pend_q), .sel(prog_sel)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign is_hit    = found && active_vld_q && (found_idx == active_q);
  assign is_switch = found && !is_hit;
  assign is_load   = !found;
  assign touch_idx = found ? found_idx : victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags_q         <= '0;
      filled_q       <= '0;
      active_q       <= '0;
      active_vld_q   <= 1'b0;
      pend_q         <= '0;
      busy_q         <= 1'b0;
      timer_q        <= '0;
      load_start     <= 1'b0;
      load_plane     <= '0;
      load_ctx       <= '0;
      evt_valid      <= 1'b0;
      evt_kind       <= OUT_HIT;
      load_count     <= '0;
      switch_count   <= '0;
      overhead_total <= '0;
    end else begin
      load_start <= 1'b0;
      evt_valid  <= 1'b0;
      if (busy_q) begin
        if (timer_q == '0) begin
          busy_q       <= 1'b0;
          active_q     <= pend_q;
          active_vld_q <= 1'b1;
        end else begin
          timer_q <= timer_q - 1'b1;
        end
      end else if (accept) begin
        evt_valid <= 1'b1;
        if (is_hit) begin
          evt_kind <= OUT_HIT;
        end else if (is_switch) begin
          evt_kind       <= OUT_SWITCH;
          active_q       <= found_idx;
          switch_count   <= switch_count + 1'b1;
          overhead_total <= overhead_total + OVH_W'(switch_cost);
        end else begin
          evt_kind         <= OUT_LOAD;
          tags_q[victim]   <= req_ctx;
          filled_q[victim] <= 1'b1;
          pend_q           <= victim;
          busy_q           <= 1'b1;
          timer_q          <= TMR_W'(LOAD_CYCLES - 1);
          load_start       <= 1'b1;
          load_plane       <= victim;
          load_ctx         <= req_ctx;
          load_count       <= load_count + 1'b1;
          overhead_total   <= overhead_total + OVH_W'(load_cost);
        end
      end
    end
  end

  assert_sel_onehot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_sel));

  assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hit) |=> ($stable(overhead_total) && $stable(plane_sel)
                            && $stable(load_count) && $stable(switch_count)));

  assert_switch_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_switch) |=> (plane_sel != $past(plane_sel)) && (evt_kind == OUT_SWITCH));

  assert_load_counted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_load) |=> load_start && (load_count == $past(load_count) + 1'b1));

  assert_load_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> (!req_ready && $onehot(prog_sel)));

  assert_no_switch_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $stable(switch_count));
endmodule

// File: tb/ctx_plane_mgr_tb.sv
module ctx_plane_mgr_tb;
  localparam int NP = 4;
  localparam int LC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_ctx = '0;
  logic [15:0] load_cost = 16'd100;
  logic [15:0] switch_cost = 16'd3;
  logic [3:0]  plane_sel, prog_sel;
  logic        load_start;
  logic [1:0]  load_plane;
  logic [7:0]  load_ctx;
  logic        evt_valid;
  logic [1:0]  evt_kind;
  logic [15:0] load_count, switch_count;
  logic [39:0] overhead_total;

  always #2 clk = ~clk;

  ctx_plane_mgr #(.LOAD_CYCLES(LC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .load_cost(load_cost), .switch_cost(switch_cost),
    .plane_sel(plane_sel), .prog_sel(prog_sel), .load_start(load_start),
    .load_plane(load_plane), .load_ctx(load_ctx), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .load_count(load_count), .switch_count(switch_count),
    .overhead_total(overhead_total)
  );

  // behavioural reference
  int     m_tag[NP];
  bit     m_filled[NP];
  int     m_active;
  bit     m_active_vld;
  bit     m_busy;
  int     m_timer;
  int     m_pend;
  int     lru[$];
  bit     m_evt_valid, m_load_start;
  int     m_evt_kind, m_load_plane, m_load_ctx;
  longint m_loads, m_switches, m_ovh;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_tag[p] = 0; m_filled[p] = 0; end
      m_active = 0; m_active_vld = 0; m_busy = 0; m_timer = 0; m_pend = 0;
      lru = {0, 1, 2, 3};
      m_evt_valid = 0; m_load_start = 0; m_evt_kind = 0;
      m_load_plane = 0; m_load_ctx = 0;
      m_loads = 0; m_switches = 0; m_ovh = 0;
    end else begin
      m_evt_valid = 0;
      m_load_start = 0;
      if (m_busy) begin
        if (m_timer == 0) begin
          m_busy = 0; m_active = m_pend; m_active_vld = 1;
        end else m_timer--;
      end else if (req_valid) begin
        int hit_idx, tgt;
        hit_idx = -1;
        for (int p = NP - 1; p >= 0; p--)
          if (m_filled[p] && m_tag[p] == int'(req_ctx)) hit_idx = p;
        m_evt_valid = 1;
        if (hit_idx >= 0 && m_active_vld && hit_idx == m_active) begin
          m_evt_kind = 0; tgt = hit_idx;
        end else if (hit_idx >= 0) begin
          m_evt_kind = 1; tgt = hit_idx; m_active = hit_idx;
          m_switches++; m_ovh += longint'(switch_cost);
        end else begin
          tgt = -1;
          for (int p = NP - 1; p >= 0; p--) if (!m_filled[p]) tgt = p;
          if (tgt < 0) tgt = lru[$];
          m_evt_kind = 2;
          m_tag[tgt] = int'(req_ctx); m_filled[tgt] = 1;
          m_pend = tgt; m_busy = 1; m_timer = LC - 1;
          m_load_start = 1; m_load_plane = tgt; m_load_ctx = int'(req_ctx);
          m_loads++; m_ovh += longint'(load_cost);
        end
        for (int i = 0; i < lru.size(); i++)
          if (lru[i] == tgt) begin lru.delete(i); break; end
        lru.push_front(tgt);
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R9", "req_ready", longint'(req_ready), longint'(!m_busy));
      chk("R1", "plane_sel", longint'(plane_sel), m_active_vld ? longint'(1 << m_active) : 0);
      chk("R7", "prog_sel", longint'(prog_sel), m_busy ? longint'(1 << m_pend) : 0);
      chk("R2", "evt_valid", longint'(evt_valid), longint'(m_evt_valid));
      if (m_evt_valid) chk("R3", "evt_kind", longint'(evt_kind), longint'(m_evt_kind));
      chk("R4", "load_start", longint'(load_start), longint'(m_load_start));
      if (m_load_start) begin
        chk("R6", "load_plane", longint'(load_plane), longint'(m_load_plane));
        chk("R5", "load_ctx", longint'(load_ctx), longint'(m_load_ctx));
      end
      chk("R4", "load_count", longint'(load_count), m_loads & 64'hFFFF);
      chk("R3", "switch_count", longint'(switch_count), m_switches & 64'hFFFF);
      chk("R8", "overhead_total", longint'(overhead_total), m_ovh & 64'hFF_FFFF_FFFF);
    end
  end

  // back-to-back stream; valid held through stalls (R10)
  task automatic stream(input int ctxs[]);
    foreach (ctxs[i]) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_ctx = 8'(ctxs[i]);
      while (!req_ready) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R5 fill order, R2 hit, R3 switch, R6 eviction
    stream('{10, 10, 20, 10, 30, 40, 20, 10, 50, 30, 60, 20});
    repeat (3) @(negedge clk);
    // R8: weights change while a load is in flight
    fork
      stream('{70, 10, 60, 60, 50, 70, 80});
      begin repeat (3) @(negedge clk); load_cost = 16'd1234; switch_cost = 16'd17; end
    join
    // long reshuffling streams over six contexts
    for (int r = 0; r < 40; r++) begin
      int s[];
      s = new[12];
      foreach (s[i]) s[i] = 1 + ((i * 5 + r * 3 + (i * r) / 4) % 6);
      if (r == 20) begin load_cost = 16'hFFFF; switch_cost = 16'd1; end
      stream(s);
      if (r % 5 == 0) repeat (2) @(negedge clk);
    end
    repeat (LC + 4) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule